// File: doc/BRIEF.md
# NCO Baud Tick Generator

This block derives the serial bit-rate enable for a UART from the system clock with a numerically controlled oscillator. Every clock cycle a 16-bit increment is added to a 20-bit phase accumulator. The carry out of that addition becomes a one-cycle baud tick. The resulting rate is fractional: tick rate = increment × f_clk / 2^20. An integer divider would restrict the rate to f_clk / N.

A character pacer sits on top of the tick stream. While transmit is enabled, it counts baud ticks. It raises a one-cycle character-done pulse once ten ticks have passed, which covers one start bit, eight data bits and one stop bit. It then starts again from zero. The surrounding transmitter uses that pulse to pop its FIFO. Software can change the increment on the fly. The accumulator keeps its phase, so the new rate applies from the next wrap onward and no reset is needed.

Top module: `baud_nco_gen`

## Requirements
- R1: While reset (rstN low) is asserted, the accumulator and bit counter are cleared and both outputs are low. After release with a constant increment `incr`, the first baudTick is seen in the cycle after clock edge ceil(2^20 / incr).
- R2: `incr` is an unsigned 16-bit value, zero-extended into the 20-bit accumulator. The maximum value 0xFFFF is valid and gives floor(N × 65535 / 2^20) ticks in N cycles.
- R3: With a constant increment, the number of baudTick cycles in the first N cycles after reset equals floor(N × incr / 2^20). Each tick is exactly one cycle wide and never follows another tick directly.
- R4: An increment of zero produces no baudTick.
- R5: With txEnable high, charDone pulses for exactly one cycle, in the cycle after the tenth counted baudTick. Counting then restarts, so the next pulse follows ten more ticks.
- R6: While txEnable is low, the bit counter is held at zero and charDone stays low. After txEnable rises, ten fresh ticks are needed before the next charDone.
- R7: A change of `incr` without reset keeps the accumulator phase. From the next cycle on, each cycle adds the new increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| incr | input | 16 | NCO phase increment (upper half of the UART control word) |
| txEnable | input | 1 | Transmit enable; low holds the character pacer in reset |
| baudTick | output | 1 | One-cycle bit-rate enable (accumulator carry) |
| charDone | output | 1 | One-cycle pulse after ten bit times |

## Verification
The bench builds the block with its default parameters: a 20-bit accumulator, a 16-bit increment and ten bits per character. At these values an increment of 0xFFFF gives a tick about every 16 cycles, so many full characters, wraps and mid-run increment changes fit into a short run. Low increments such as 0x1000 make the first-tick position after reset an exact round number, 256 cycles. The phase carried across increment changes and enable toggles is tracked cycle by cycle in the bench. The mutations that matter are the carry position, the counter wrap value and the enable gating, and this tracking reaches each of them.

// File: rtl/baud_nco_pkg.sv
package baud_nco_pkg;
  // strobes from the character control to the datapath counter
  typedef struct packed {
    logic bitInc;
    logic bitClear;
  } nco_strobe_t;
endpackage

// File: rtl/baud_nco_dp.sv
module baud_nco_dp
  import baud_nco_pkg::*;
#(
  parameter int ACC_W = 20,
  parameter int INC_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [INC_W-1:0] incr,
  input  nco_strobe_t      strobe,
  output logic             carryTick,
  output logic [CNT_W-1:0] bitCount
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] phaseAcc;
  logic [SUM_W-1:0] phaseSum;

  assign phaseSum = {1'b0, phaseAcc} + SUM_W'(incr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc  <= '0;
      carryTick <= 1'b0;
    end else begin
      phaseAcc  <= phaseSum[ACC_W-1:0];
      carryTick <= phaseSum[ACC_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (strobe.bitClear) begin
      bitCount <= '0;
    end else if (strobe.bitInc) begin
      bitCount <= bitCount + CNT_W'(1);
    end
  end
endmodule

// File: rtl/baud_nco_ctl.sv
module baud_nco_ctl
  import baud_nco_pkg::*;
#(
  parameter int BITS_PER_CHAR = 10,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic             carryTick,
  input  logic [CNT_W-1:0] bitCount,
  output nco_strobe_t      strobe,
  output logic             charDone
);
  logic lastBit;
  logic finishChar;

  assign lastBit    = (bitCount == CNT_W'(BITS_PER_CHAR - 1));
  assign finishChar = txEnable && carryTick && lastBit;

  always_comb begin
    strobe.bitClear = !txEnable || finishChar;
    strobe.bitInc   = txEnable && carryTick && !lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) charDone <= 1'b0;
    else       charDone <= finishChar;
  end
endmodule

// File: rtl/baud_nco_gen.sv
module baud_nco_gen
  import baud_nco_pkg::*;
#(
  parameter int ACC_W = 20,
  parameter int INC_W = 16,
  parameter int BITS_PER_CHAR = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [INC_W-1:0] incr,
  input  logic             txEnable,
  output logic             baudTick,
  output logic             charDone
);
  localparam int CNT_W = $clog2(BITS_PER_CHAR);

  nco_strobe_t      strobe;
  logic [CNT_W-1:0] bitCount;

  baud_nco_dp #(.ACC_W(ACC_W), .INC_W(INC_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .incr(incr), .strobe(strobe),
    .carryTick(baudTick), .bitCount(bitCount)
  );

  baud_nco_ctl #(.BITS_PER_CHAR(BITS_PER_CHAR), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .carryTick(baudTick),
    .bitCount(bitCount), .strobe(strobe), .charDone(charDone)
  );
endmodule

// File: rtl/baud_nco_chk.sv
module baud_nco_chk #(
  parameter int INC_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [INC_W-1:0] incr,
  input logic             txEnable,
  input logic             baudTick,
  input logic             charDone
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!baudTick && !charDone));

  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |=> !baudTick);

  // R4
  zero_incr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (incr == '0) |=> !baudTick);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    charDone |=> !charDone);

  // R5
  done_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    charDone |-> ($past(baudTick) && $past(txEnable)));

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> !charDone);
endmodule

bind baud_nco_gen baud_nco_chk #(.INC_W(INC_W)) u_chk (
  .clk(clk), .rstN(rstN), .incr(incr), .txEnable(txEnable),
  .baudTick(baudTick), .charDone(charDone)
);

// File: tb/test_baud_nco_gen.sv
module test_baud_nco_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] incr = '0;
  logic        txEnable = 1'b0;
  logic        baudTick;
  logic        charDone;

  int total = 0;
  int bad = 0;
  int tickSeen = 0;
  int doneSeen = 0;
  bit finished = 0;

  // bench reference state
  longint mPhase = 0;
  bit     mTick = 0;
  int     mCnt = 0;
  bit     mDone = 0;

  always #2 clk = ~clk;

  baud_nco_gen i_baud_nco_gen (
    .clk(clk), .rstN(rstN), .incr(incr), .txEnable(txEnable),
    .baudTick(baudTick), .charDone(charDone)
  );

  function automatic longint ticksIn(longint n, longint inc);
    return (n * inc) >> 20;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelEdge();
    longint sum;
    sum = mPhase + longint'(incr);
    if (!txEnable) begin
      mCnt = 0; mDone = 0;
    end else if (mTick) begin
      if (mCnt == 9) begin mCnt = 0; mDone = 1; end
      else begin mCnt++; mDone = 0; end
    end else begin
      mDone = 0;
    end
    mTick  = sum[20];
    mPhase = sum & 64'hFFFFF;
  endtask

  task automatic step(string req);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    if (baudTick) tickSeen++;
    if (charDone) doneSeen++;
    check(req, "baudTick", longint'(baudTick), longint'(mTick));
    check(req == "R6" ? "R6" : "R5", "charDone", longint'(charDone), longint'(mDone));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    mPhase = 0; mTick = 0; mCnt = 0; mDone = 0;
    check("R1", "baudTick in reset", longint'(baudTick), 0);
    check("R1", "charDone in reset", longint'(charDone), 0);
    rstN = 1'b1;
    tickSeen = 0; doneSeen = 0;
  endtask

  initial begin
    int firstTick;
    void'($urandom(32'h1234_5EED));
    doReset();

    // R4: zero increment gives no ticks
    incr = 16'h0000; txEnable = 1'b1;
    repeat (300) step("R4");
    check("R4", "ticks with zero incr", tickSeen, 0);

    // R1 / R3: first tick position and tick count over a window
    doReset();
    incr = 16'h1000; txEnable = 1'b1;
    firstTick = 0;
    for (int c = 1; c <= 2000; c++) begin
      step("R3");
      if (baudTick && firstTick == 0) firstTick = c;
    end
    check("R1", "first tick cycle", firstTick, 256);
    check("R3", "tick count 0x1000", tickSeen, ticksIn(2000, 16'h1000));
    check("R5", "done count 0x1000", doneSeen, ticksIn(2000, 16'h1000) / 10);

    // R2: maximum increment
    doReset();
    incr = 16'hFFFF; txEnable = 1'b1;
    repeat (5000) step("R2");
    check("R2", "tick count 0xFFFF", tickSeen, ticksIn(5000, 16'hFFFF));
    check("R5", "done count 0xFFFF", doneSeen, ticksIn(5000, 16'hFFFF) / 10);

    // R6: transmit disabled while ticks keep running
    doReset();
    incr = 16'hF000; txEnable = 1'b0;
    repeat (800) step("R6");
    check("R6", "done count while disabled", doneSeen, 0);
    txEnable = 1'b1;
    doneSeen = 0; tickSeen = 0;
    while (tickSeen < 9) step("R6");
    check("R6", "no done after 9 fresh ticks", doneSeen, 0);
    while (tickSeen < 10) step("R6");
    step("R6");
    check("R6", "done after 10th fresh tick", doneSeen, 1);

    // R6: random enable toggling
    for (int s = 0; s < 20; s++) begin
      incr = 16'($urandom_range(16'hFFFF, 16'h4000));
      txEnable = 1'($urandom_range(1, 0));
      repeat ($urandom_range(300, 30)) step("R6");
    end

    // R7: increment changes without reset, phase carried over
    txEnable = 1'b1;
    for (int s = 0; s < 40; s++) begin
      case (s % 5)
        0: incr = 16'h0000;
        1: incr = 16'hFFFF;
        default: incr = 16'($urandom_range(16'hFFFF, 0));
      endcase
      repeat ($urandom_range(300, 50)) step("R7");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #600000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule